// File: doc/BRIEF.md
# Flash Erase Block Select Controller

This block guards erase access to a 32 KB on-chip flash array. Software programs a select register in which at most one bit may be set, and that bit names the only block that an erase may touch. Every other block stays protected. The register only holds a value while the software write enable from the flash control logic is high. When that enable is low the register is cleared and kept at zero. A write that sets more than one select bit wipes the register instead of storing the value, so a mistaken write cannot leave two blocks exposed together.

The flash is split unevenly. The four lowest 1 KB regions are blocks 0 to 3, and everything from 0x1000 up to 0x7FFF is block 4. For each erase request the block decodes the 15-bit address into a block index and raises a permit flag only when that block is the one selected. To clear the whole array, software selects and erases each block in turn.

A second one-bit register decides whether the flash is powered down when the chip enters its sub-active low-power mode.

Top module: `flash_erase_ctl`

## Requirements
- R1: On reset (rst_ni low, asynchronous) the select register and the power-down disable bit are both 0.
- R2: While swe_i is 0, reads of the select register (reg_sel_i=0) return 0x00 and writes to it are ignored. The stored select value is cleared at the next rising clock edge and stays 0 until a new write is made with swe_i at 1.
- R3: With swe_i at 1, a write to the select register (reg_we_i=1, reg_sel_i=0) whose bits [4:0] contain at most one set bit stores those bits at the next rising edge. Bit n selects block n. Read bits [7:5] always return 0, and written bits [7:5] have no effect.
- R4: With swe_i at 1, a select write whose bits [4:0] contain two or more set bits leaves the select register at 0x00 after the next rising edge.
- R5: blk_idx_o is combinational on erase_addr_i. It is 0 to 3 for addresses 0x0000–0x03FF, 0x0400–0x07FF, 0x0800–0x0BFF and 0x0C00–0x0FFF respectively, and 4 for 0x1000–0x7FFF.
- R6: erase_ok_o is 1 exactly when erase_req_i is 1, swe_i is 1, and the stored select bit for the block holding erase_addr_i is set. An all-zero select value protects every block.
- R7: The power-down disable bit is bit 7 of the power register (reg_sel_i=1). It is written from reg_wdata_i[7] at the next rising edge whatever swe_i is. Read bits [6:0] of that register are 0.
- R8: flash_pd_o is 1 exactly when subactive_i is 1 and the power-down disable bit is 0.
- R9: reg_rdata_o shows the register chosen by reg_sel_i in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| swe_i | input | 1 | Software write enable from flash control |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = erase select register, 1 = power register |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| erase_req_i | input | 1 | Erase request present |
| erase_addr_i | input | 15 | Flash address of the erase request |
| erase_ok_o | output | 1 | Erase permitted for the requested address |
| blk_idx_o | output | 3 | Decoded block index of erase_addr_i |
| subactive_i | input | 1 | Chip is in sub-active mode |
| flash_pd_o | output | 1 | Flash power-down request |

## Verification
Register writes are registered, so their effect appears one rising edge after the strobe. Clearing caused by a low swe_i also shows in the stored value one edge later, although the read path masks it in the same cycle. The block decode, the erase permit, the power-down output and the read data are combinational, so they are due in the cycle their inputs change. The bench drives inputs just after a falling edge and compares every output with its behavioural model a nanosecond later, before the next rising edge. It updates the model state only at the rising edge, which keeps both timings exact.

// File: rtl/fesc_pkg.sv
package fesc_pkg;
  localparam int ADDR_W_DEF     = 15;
  localparam int SMALL_LOG2_DEF = 10;
  localparam int N_SMALL_DEF    = 4;
  localparam int DATA_W_DEF     = 8;
  localparam int PDD_BIT_DEF    = 7;

  typedef enum logic {
    REG_SEL = 1'b0,
    REG_PWR = 1'b1
  } reg_tgt_e;
endpackage

// File: rtl/fesc_blk_decode.sv
module fesc_blk_decode #(
  parameter int ADDR_W     = 15,
  parameter int SMALL_LOG2 = 10,
  parameter int N_SMALL    = 4,
  localparam int N_BLK     = N_SMALL + 1,
  localparam int IDX_W     = $clog2(N_BLK),
  localparam int PAGE_W    = ADDR_W - SMALL_LOG2,
  localparam int LARGE_BASE = N_SMALL << SMALL_LOG2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_BLK-1:0]  hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  // uniform small blocks at the bottom of the array
  for (genvar b = 0; b < N_SMALL; b++) begin : g_small
    assign hit_o[b] = addr_i[ADDR_W-1:SMALL_LOG2] == PAGE_W'(b);
  end

  // one large block covers the rest
  assign hit_o[N_SMALL] = addr_i >= ADDR_W'(LARGE_BASE);

  always_comb begin
    idx_o = '0;
    for (int b = 0; b < N_BLK; b++) begin
      if (hit_o[b]) idx_o = IDX_W'(b);
    end
  end
endmodule

// File: rtl/fesc_sel_reg.sv
module fesc_sel_reg #(
  parameter int N_BLK = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             swe_i,
  input  logic             wr_i,
  input  logic [N_BLK-1:0] wdata_i,
  output logic [N_BLK-1:0] sel_o
);
  logic [N_BLK-1:0] sel_q;
  logic             multi;

  assign multi = $countones(wdata_i) > 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (!swe_i)  sel_q <= '0;
    else if (wr_i)    sel_q <= multi ? '0 : wdata_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/fesc_pwr_reg.sv
module fesc_pwr_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  output logic pdd_o
);
  logic pdd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pdd_q <= 1'b0;
    else if (wr_i) pdd_q <= wbit_i;
  end

  assign pdd_o = pdd_q;
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
  import fesc_pkg::*;
#(
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter int SMALL_LOG2 = SMALL_LOG2_DEF,
  parameter int N_SMALL    = N_SMALL_DEF,
  parameter int DATA_W     = DATA_W_DEF,
  parameter int PDD_BIT    = PDD_BIT_DEF,
  localparam int N_BLK     = N_SMALL + 1,
  localparam int IDX_W     = $clog2(N_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swe_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              erase_req_i,
  input  logic [ADDR_W-1:0] erase_addr_i,
  output logic              erase_ok_o,
  output logic [IDX_W-1:0]  blk_idx_o,
  input  logic              subactive_i,
  output logic              flash_pd_o
);
  reg_tgt_e         tgt;
  logic             wr_sel, wr_pwr;
  logic [N_BLK-1:0] sel_q;
  logic [N_BLK-1:0] hit;
  logic             pdd_q;

  assign tgt    = reg_tgt_e'(reg_sel_i);
  assign wr_sel = reg_we_i && (tgt == REG_SEL);
  assign wr_pwr = reg_we_i && (tgt == REG_PWR);

  fesc_sel_reg #(.N_BLK(N_BLK)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .swe_i   (swe_i),
    .wr_i    (wr_sel),
    .wdata_i (reg_wdata_i[N_BLK-1:0]),
    .sel_o   (sel_q)
  );

  fesc_pwr_reg u_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_pwr),
    .wbit_i (reg_wdata_i[PDD_BIT]),
    .pdd_o  (pdd_q)
  );

  fesc_blk_decode #(
    .ADDR_W     (ADDR_W),
    .SMALL_LOG2 (SMALL_LOG2),
    .N_SMALL    (N_SMALL)
  ) u_dec (
    .addr_i (erase_addr_i),
    .hit_o  (hit),
    .idx_o  (blk_idx_o)
  );

  // read masks the select value at once when swe drops
  always_comb begin
    reg_rdata_o = '0;
    if (tgt == REG_SEL) reg_rdata_o[N_BLK-1:0] = sel_q & {N_BLK{swe_i}};
    else                reg_rdata_o[PDD_BIT]   = pdd_q;
  end

  assign erase_ok_o = erase_req_i && swe_i && |(sel_q & hit);
  assign flash_pd_o = subactive_i && !pdd_q;
endmodule

// File: rtl/flash_erase_ctl_chk.sv
module flash_erase_ctl_chk #(
  parameter int N_BLK  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              swe_i,
  input logic              reg_we_i,
  input logic              reg_sel_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              erase_req_i,
  input logic              erase_ok_o,
  input logic              subactive_i,
  input logic              flash_pd_o,
  input logic [N_BLK-1:0]  sel_q,
  input logic              pdd_q
);
  p_hold_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swe_i |=> sel_q == '0);

  p_read_masked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swe_i && !reg_sel_i) |-> reg_rdata_o == '0);

  p_store_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swe_i && reg_we_i && !reg_sel_i && $countones(reg_wdata_i[N_BLK-1:0]) <= 1)
    |=> sel_q == $past(reg_wdata_i[N_BLK-1:0]));

  p_multi_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swe_i && reg_we_i && !reg_sel_i && $countones(reg_wdata_i[N_BLK-1:0]) > 1)
    |=> sel_q == '0);

  p_one_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));

  p_erase_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_ok_o |-> (erase_req_i && swe_i && sel_q != '0));

  p_pwr_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i) |=> pdd_q == $past(reg_wdata_i[DATA_W-1]));

  p_pd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (subactive_i && pdd_q) |-> !flash_pd_o);

  p_pd_only_sub_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_pd_o |-> subactive_i);
endmodule

bind flash_erase_ctl flash_erase_ctl_chk #(.N_BLK(N_BLK), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .swe_i       (swe_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .erase_req_i (erase_req_i),
  .erase_ok_o  (erase_ok_o),
  .subactive_i (subactive_i),
  .flash_pd_o  (flash_pd_o),
  .sel_q       (sel_q),
  .pdd_q       (pdd_q)
);

// File: tb/tb_flash_erase_ctl.sv
`timescale 1ns/1ps
module tb_flash_erase_ctl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        swe_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        erase_req_i = 1'b0;
  logic [14:0] erase_addr_i = '0;
  logic        erase_ok_o;
  logic [2:0]  blk_idx_o;
  logic        subactive_i = 1'b0;
  logic        flash_pd_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  int m_sel = 0;
  int m_pdd = 0;

  always #2 clk_i = ~clk_i;

  flash_erase_ctl dut (.*);

  function automatic int exp_blk(int a);
    return (a < 'h1000) ? a / 1024 : 4;
  endfunction

  function automatic int ones5(int v);
    int c = 0;
    for (int i = 0; i < 5; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare all outputs against model, then advance one clock
  task automatic step(string tag);
    int rd, ok, blk;
    #1;
    blk = exp_blk(int'(erase_addr_i));
    if (reg_sel_i) rd = m_pdd << 7;
    else           rd = swe_i ? m_sel : 0;
    ok = (erase_req_i && swe_i && ((m_sel >> blk) & 1)) ? 1 : 0;
    chk(tag, "rdata", int'(reg_rdata_o), rd);
    chk(tag, "blk_idx", int'(blk_idx_o), blk);
    chk(tag, "erase_ok", int'(erase_ok_o), ok);
    chk(tag, "flash_pd", int'(flash_pd_o), (subactive_i && !m_pdd) ? 1 : 0);
    @(posedge clk_i);
    if (!swe_i) m_sel = 0;
    else if (reg_we_i && !reg_sel_i)
      m_sel = (ones5(int'(reg_wdata_i)) > 1) ? 0 : int'(reg_wdata_i) & 'h1f;
    if (reg_we_i && reg_sel_i) m_pdd = int'(reg_wdata_i[7]);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic wr(bit tgt, logic [7:0] d, string tag);
    reg_sel_i = tgt; reg_wdata_i = d; reg_we_i = 1'b1;
    step(tag);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    step("R1");
    reg_sel_i = 1'b1; step("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 writes ignored while swe low
    swe_i = 1'b0;
    wr(1'b0, 8'h04, "R2");
    reg_sel_i = 1'b0; step("R2");

    // R3 single-bit write, upper bits ignored, R9 same-cycle read
    swe_i = 1'b1;
    wr(1'b0, 8'he2, "R3");
    step("R9");
    for (int b = 0; b < 5; b++) begin
      wr(1'b0, 8'(1 << b), "R3");
      for (int k = 0; k < 8; k++) begin
        erase_req_i = 1'b1;
        erase_addr_i = 15'($urandom_range(0, 'h7fff));
        step("R6");
      end
      // address inside the selected block
      erase_addr_i = (b < 4) ? 15'(b * 1024 + 5) : 15'h7fff;
      step("R6");
    end
    erase_req_i = 1'b0; step("R6");

    // R4 multi-bit write clears
    wr(1'b0, 8'h02, "R4");
    wr(1'b0, 8'h11, "R4");
    step("R4");
    wr(1'b0, 8'h08, "R4");
    wr(1'b0, 8'h1f, "R4");
    step("R4");

    // R6 zero write protects all
    wr(1'b0, 8'h00, "R6");
    erase_req_i = 1'b1;
    erase_addr_i = 15'h0000; step("R6");
    erase_addr_i = 15'h2000; step("R6");

    // R2 swe drop clears and stays clear
    wr(1'b0, 8'h10, "R2");
    erase_addr_i = 15'h4000; step("R6");
    swe_i = 1'b0; step("R2");
    step("R2");
    swe_i = 1'b1; step("R2");
    erase_req_i = 1'b0;

    // R5 block boundaries
    foreach (erase_addr_i[i]) ;
    for (int a = 0; a < 10; a++) begin
      int pts[10] = '{'h0000, 'h03ff, 'h0400, 'h07ff, 'h0800,
                      'h0bff, 'h0c00, 'h0fff, 'h1000, 'h7fff};
      erase_addr_i = 15'(pts[a]);
      step("R5");
    end

    // R7 / R8 power register
    subactive_i = 1'b1; step("R8");
    wr(1'b1, 8'h7f, "R7");
    wr(1'b1, 8'h80, "R7");
    step("R8");
    swe_i = 1'b0;
    wr(1'b1, 8'h00, "R7");
    step("R8");
    subactive_i = 1'b0; step("R8");
    wr(1'b1, 8'hff, "R7");
    subactive_i = 1'b1; step("R8");

    // R1 async reset mid-run
    swe_i = 1'b1;
    wr(1'b0, 8'h01, "R1");
    rst_ni = 1'b0;
    m_sel = 0; m_pdd = 0;
    #1;
    reg_sel_i = 1'b0; step("R1");
    reg_sel_i = 1'b1;
    #1;
    chk("R1", "rdata_pwr", int'(reg_rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule